// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block is a parallel I/O adapter that sits on a processor bus. The bus side is synchronous to `clk` and has an 8-bit write path, an 8-bit read path, a two-bit register select, an active-low chip select and active-low read and write strobes. Every cycle in which select and a strobe are both low counts as one access, so no access ever waits. On the peripheral side there are 24 lines, each modelled as a pad with separate output, output-enable and input vectors. They form two 8-bit ports, A and B, and one 8-bit port C. Port C is split into an upper nibble, which belongs to control group A with port A, and a lower nibble, which belongs to control group B with port B.

A mode word written to the control address sets up both groups. In basic mode each of the four port sections is a plain input or a latched output. In strobed mode, port A or port B becomes a handshaked input or output bus, and fixed port C lines take on the strobe, acknowledge, buffer-full and interrupt roles. In bidirectional mode, port A carries handshaked traffic in both directions while port B keeps working on its own. A second control command sets or clears a single port C latch bit. That same latch bit also serves as the interrupt enable for a handshake input line.

Handshake inputs arriving from the peripheral pass through a reset-to-idle synchronizer of `SYNC_STAGES` flops before they take effect.

Top module: `ppi_top`

## Requirements
- R1: After reset, every output enable is low, a read of the control address (`addr`=3) returns 8'h9B, and all four port sections act as basic-mode inputs, so a read of port A returns the live `pa_in`.
- R2: `addr` selects port A (0), port B (1), port C (2) or the control register (3). A read of address 3 returns the last mode word written.
- R3: A control write with bit 7 = 1 is a mode word with these fields: bits 6:5 set the group A mode (00 basic, 01 strobed, 1x bidirectional); bit 4 sets the port A direction; bit 3 the port C upper direction; bit 2 the group B mode (0 basic, 1 strobed); bit 1 the port B direction; bit 0 the port C lower direction. A direction bit of 1 means input. In basic mode each section's output enables are all high when it is an output and all low when it is an input.
- R4: A basic-mode output port drives the written value on its pins from the clock edge that captures the write. A read of that port returns the written value.
- R5: A basic-mode input port or nibble reads the present pin values, and a later pin change shows up on the next read with no capture.
- R6: A control write with bit 7 = 0 sets port C latch bit `wdata[3:1]` to `wdata[0]` and leaves the other seven latch bits unchanged.
- R7: A mode word write clears the port A, B and C output latches and every handshake flag.
- R8: Strobed input on port A uses PC4 as the active-low strobe, PC5 as buffer-full and PC3 as the interrupt. A falling strobe captures `pa_in` and sets buffer-full. The interrupt rises when the strobe returns high while buffer-full is set and the PC4 latch bit (the enable) is 1. A read of port A returns the captured byte and clears both buffer-full and the interrupt.
- R9: In strobed output, a port write drives the active-low output-full line low and clears the interrupt. A falling acknowledge sets output-full high again. A rising acknowledge raises the interrupt if that acknowledge line's enable latch bit is 1.
- R10: Group B in strobed mode uses PC2 as strobe or acknowledge, PC1 as buffer-full or active-low output-full, and PC0 as the interrupt. The PC2 latch bit is its interrupt enable.
- R11: In bidirectional mode, PC7 is output-full (active low), PC6 acknowledge, PC5 buffer-full, PC4 strobe and PC3 the interrupt (the OR of the input and output causes, each gated by its PC4 or PC6 enable). Port A drives its pins only while acknowledge is low. Port B keeps its own mode.
- R12: A port C read returns the line value for a handshake output, the enable latch bit for a handshake input, the latch for a plain output bit and the pin for a plain input bit. Only handshake outputs and plain output bits are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor (combinational) |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C pin drive values |
| pc_oe | output | 8 | Port C output enables |

## Verification
Read data is combinational, so the monitor compares `rdata` at the falling edge in the middle of each one-cycle read. Register writes and bit set/reset take effect at the edge that captures the strobe, so pin checks are made 2 ns after that edge. A change on a handshake pin reaches the flags `SYNC_STAGES`+1 rising edges after it is driven. The bench therefore waits `SYNC_STAGES`+2 edges after each strobe or acknowledge move before it checks port C. The flag changes that a read causes happen at the end of that read cycle, and the bench checks them after the read.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam logic [1:0] ADDR_PA  = 2'd0;
  localparam logic [1:0] ADDR_PB  = 2'd1;
  localparam logic [1:0] ADDR_PC  = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;
  localparam logic [7:0] MODE_RESET = 8'h9B;

  typedef struct packed {
    logic [1:0] ga_mode;
    logic       a_in;
    logic       cu_in;
    logic       gb_strobed;
    logic       b_in;
    logic       cl_in;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] w);
    mode_t m;
    m.ga_mode    = w[6:5];
    m.a_in       = w[4];
    m.cu_in      = w[3];
    m.gb_strobed = w[2];
    m.b_in       = w[1];
    m.cl_in      = w[0];
    return m;
  endfunction
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int         N       = 3,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [N-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    mode_o,
  output logic [DW-1:0] pa_lat_o,
  output logic [DW-1:0] pb_lat_o,
  output logic [CW-1:0] pc_lat_o,
  output logic          mode_wr_o
);
  logic [7:0]    mode_q, mode_d;
  logic [DW-1:0] pa_q, pa_d, pb_q, pb_d;
  logic [CW-1:0] pc_q, pc_d;
  logic          ctl_wr, bsr_wr, mode_wr, reg_en;

  assign ctl_wr  = wr_en && (addr == ADDR_CTL);
  assign mode_wr = ctl_wr && wdata[7];
  assign bsr_wr  = ctl_wr && !wdata[7];
  assign reg_en  = wr_en;

  always_comb begin
    mode_d = mode_q;
    pa_d   = pa_q;
    pb_d   = pb_q;
    pc_d   = pc_q;
    unique case (addr)
      ADDR_PA: pa_d = wdata;
      ADDR_PB: pb_d = wdata;
      ADDR_PC: pc_d = wdata;
      default: begin
        if (wdata[7]) begin
          mode_d = wdata;
          pa_d   = '0;
          pb_d   = '0;
          pc_d   = '0;
        end else begin
          pc_d[wdata[3:1]] = wdata[0];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      pa_q   <= '0;
      pb_q   <= '0;
      pc_q   <= '0;
    end else if (reg_en) begin
      mode_q <= mode_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      pc_q   <= pc_d;
    end
  end

  assign mode_o    = mode_q;
  assign pa_lat_o  = pa_q;
  assign pb_lat_o  = pb_q;
  assign pc_lat_o  = pc_q;
  assign mode_wr_o = mode_wr;

  // R7
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));

  // R6
  bsr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> (pc_q[$past(wdata[3:1])] == $past(wdata[0])));

  // R6
  bsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> (((pc_q ^ $past(pc_q)) & ~(8'b1 << $past(wdata[3:1]))) == 8'h00));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));
endmodule

// File: rtl/ppi_hs_chan.sv
module ppi_hs_chan
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en_in,
  input  logic          en_out,
  input  logic          stb_n,
  input  logic          ack_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          inte_in,
  input  logic          inte_out,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] lat_o,
  output logic          ibf_o,
  output logic          obf_o,
  output logic          intr_o
);
  logic          stb_prev_q, ack_prev_q;
  logic          stb_fall, stb_rise, ack_fall, ack_rise;
  logic          ibf_q, ibf_d, obf_q, obf_d;
  logic          iin_q, iin_d, iout_q, iout_d;
  logic [DW-1:0] lat_q, lat_d;
  logic          lat_en;

  assign stb_fall = stb_prev_q && !stb_n;
  assign stb_rise = !stb_prev_q && stb_n;
  assign ack_fall = ack_prev_q && !ack_n;
  assign ack_rise = !ack_prev_q && ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b1;
      ack_prev_q <= 1'b1;
    end else begin
      stb_prev_q <= stb_n;
      ack_prev_q <= ack_n;
    end
  end

  assign lat_en = clr || (en_in && stb_fall);
  assign lat_d  = clr ? '0 : din;

  always_comb begin
    ibf_d  = ibf_q;
    iin_d  = iin_q;
    obf_d  = obf_q;
    iout_d = iout_q;
    if (en_in) begin
      if (cpu_rd) begin
        ibf_d = 1'b0;
        iin_d = 1'b0;
      end
      if (stb_fall)          ibf_d = 1'b1;
      if (stb_rise && ibf_q) iin_d = 1'b1;
    end else begin
      ibf_d = 1'b0;
      iin_d = 1'b0;
    end
    if (en_out) begin
      if (cpu_wr) begin
        obf_d  = 1'b1;
        iout_d = 1'b0;
      end
      if (ack_fall)           obf_d  = 1'b0;
      if (ack_rise && !obf_q) iout_d = 1'b1;
    end else begin
      obf_d  = 1'b0;
      iout_d = 1'b0;
    end
    if (clr) begin
      ibf_d  = 1'b0;
      iin_d  = 1'b0;
      obf_d  = 1'b0;
      iout_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q  <= 1'b0;
      iin_q  <= 1'b0;
      obf_q  <= 1'b0;
      iout_q <= 1'b0;
    end else begin
      ibf_q  <= ibf_d;
      iin_q  <= iin_d;
      obf_q  <= obf_d;
      iout_q <= iout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign lat_o  = lat_q;
  assign ibf_o  = ibf_q;
  assign obf_o  = obf_q;
  assign intr_o = (iin_q && inte_in) || (iout_q && inte_out);

  // R8
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && !clr && stb_fall) |=> ibf_q);

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && !clr && cpu_rd && !stb_fall && !stb_rise) |=> (!ibf_q && !iin_q));

  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_out && !clr && ack_fall && !cpu_wr) |=> !obf_q);

  // R9
  wr_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_out && !clr && cpu_wr && !ack_fall) |=> (obf_q && !iout_q));

  // R7
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ibf_q && !obf_q && !iin_q && !iout_q));
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam int HS_N = 3;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic          rd_en, wr_en;
  logic [7:0]    mode_q;
  logic [DW-1:0] pa_lat, pb_lat;
  logic [CW-1:0] pc_lat;
  logic          mode_wr;
  mode_t         m;

  assign rd_en = !cs_n && !rd_n;
  assign wr_en = !cs_n && !wr_n;

  ppi_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .mode_o   (mode_q),
    .pa_lat_o (pa_lat),
    .pb_lat_o (pb_lat),
    .pc_lat_o (pc_lat),
    .mode_wr_o(mode_wr)
  );

  assign m = decode_mode(mode_q);

  logic a_m0, a_m1, a_m2, b_m1;
  assign a_m0 = (m.ga_mode == 2'b00);
  assign a_m1 = (m.ga_mode == 2'b01);
  assign a_m2 = m.ga_mode[1];
  assign b_m1 = m.gb_strobed;

  // handshake inputs: [2] = PC6 ack A, [1] = PC4 strobe A, [0] = PC2 group B
  logic [HS_N-1:0] hs_s;
  ppi_sync #(.N(HS_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({pc_in[6], pc_in[4], pc_in[2]}),
    .q    (hs_s)
  );

  logic [DW-1:0] a_lat, b_lat;
  logic          a_ibf, a_obf, a_intr, b_ibf, b_obf, b_intr;
  logic          a_en_in, a_en_out, b_en_in, b_en_out;

  assign a_en_in  = (a_m1 && m.a_in) || a_m2;
  assign a_en_out = (a_m1 && !m.a_in) || a_m2;
  assign b_en_in  = b_m1 && m.b_in;
  assign b_en_out = b_m1 && !m.b_in;

  ppi_hs_chan u_chan_a (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (mode_wr),
    .en_in   (a_en_in),
    .en_out  (a_en_out),
    .stb_n   (hs_s[1]),
    .ack_n   (hs_s[2]),
    .cpu_rd  (rd_en && (addr == ADDR_PA)),
    .cpu_wr  (wr_en && (addr == ADDR_PA)),
    .inte_in (pc_lat[4]),
    .inte_out(pc_lat[6]),
    .din     (pa_in),
    .lat_o   (a_lat),
    .ibf_o   (a_ibf),
    .obf_o   (a_obf),
    .intr_o  (a_intr)
  );

  ppi_hs_chan u_chan_b (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (mode_wr),
    .en_in   (b_en_in),
    .en_out  (b_en_out),
    .stb_n   (hs_s[0]),
    .ack_n   (hs_s[0]),
    .cpu_rd  (rd_en && (addr == ADDR_PB)),
    .cpu_wr  (wr_en && (addr == ADDR_PB)),
    .inte_in (pc_lat[2]),
    .inte_out(pc_lat[2]),
    .din     (pb_in),
    .lat_o   (b_lat),
    .ibf_o   (b_ibf),
    .obf_o   (b_obf),
    .intr_o  (b_intr)
  );

  logic [CW-1:0] hs_drv, hs_inp, hs_val, plain_out, pc_rd;

  always_comb begin
    hs_drv = '0;
    hs_inp = '0;
    hs_val = '0;
    if (a_m2) begin
      hs_drv[7] = 1'b1; hs_val[7] = !a_obf;
      hs_inp[6] = 1'b1;
      hs_drv[5] = 1'b1; hs_val[5] = a_ibf;
      hs_inp[4] = 1'b1;
    end else if (a_m1 && m.a_in) begin
      hs_drv[5] = 1'b1; hs_val[5] = a_ibf;
      hs_inp[4] = 1'b1;
    end else if (a_m1) begin
      hs_drv[7] = 1'b1; hs_val[7] = !a_obf;
      hs_inp[6] = 1'b1;
    end
    if (!a_m0) begin
      hs_drv[3] = 1'b1; hs_val[3] = a_intr;
    end
    if (b_m1) begin
      hs_inp[2] = 1'b1;
      hs_drv[1] = 1'b1; hs_val[1] = m.b_in ? b_ibf : !b_obf;
      hs_drv[0] = 1'b1; hs_val[0] = b_intr;
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_pc
    if (i >= CW/2) begin : g_upper
      assign plain_out[i] = !m.cu_in;
    end else begin : g_lower
      assign plain_out[i] = !m.cl_in;
    end
    assign pc_oe[i]  = hs_drv[i] || (!hs_inp[i] && plain_out[i]);
    assign pc_out[i] = hs_drv[i] ? hs_val[i] : pc_lat[i];
    assign pc_rd[i]  = hs_drv[i] ? hs_val[i] :
                       ((hs_inp[i] || plain_out[i]) ? pc_lat[i] : pc_in[i]);
  end

  logic [DW-1:0] pa_rd, pb_rd;

  assign pa_out = pa_lat;
  assign pa_oe  = a_m2 ? {DW{!hs_s[2]}} : {DW{!m.a_in}};
  assign pa_rd  = a_en_in ? a_lat : (m.a_in ? pa_in : pa_lat);

  assign pb_out = pb_lat;
  assign pb_oe  = {DW{!m.b_in}};
  assign pb_rd  = b_en_in ? b_lat : (m.b_in ? pb_in : pb_lat);

  always_comb begin
    unique case (addr)
      ADDR_PA: rdata = pa_rd;
      ADDR_PB: rdata = pb_rd;
      ADDR_PC: rdata = pc_rd;
      default: rdata = mode_q;
    endcase
  end

  // R12
  hs_in_hiz_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pc_oe & hs_inp) == 8'h00);

  // R11
  bidir_oe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (a_m2 && hs_s[2]) |-> (pa_oe == '0));

  // R3
  basic_in_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!b_m1 && m.b_in) |-> (pb_oe == '0 && pc_oe[2:0] == (m.cl_in ? 3'b000 : 3'b111)));
endmodule

// File: tb/ppi_top_tb.sv
module ppi_top_tb;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  item_t mon_it;

  always #5 clk = ~clk;

  ppi_top #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); #2;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #2;
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(posedge clk); #2;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic settle();
    repeat (SYNC + 2) @(posedge clk);
    #2;
  endtask

  // monitor: compares read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (!cs_n && !rd_n) begin
      if (sb_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2: unexpected read, actual %02h expected none", rdata);
      end else begin
        mon_it = sb_q.pop_front();
        chk(rdata, mon_it.exp, mon_it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pa_in = 8'h5C;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk(pa_oe, 8'h00, "R1 pa_oe");
    chk(pb_oe, 8'h00, "R1 pb_oe");
    chk(pc_oe, 8'h00, "R1 pc_oe");
    bus_rd(2'd3, 8'h9B, "R1 ctl read");
    bus_rd(2'd0, 8'h5C, "R1 pa live");

    // R2 R4 basic all outputs
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, 8'h80, "R2 ctl readback");
    bus_wr(2'd0, 8'hA5);
    chk(pa_out, 8'hA5, "R4 pa_out");
    chk(pa_oe, 8'hFF, "R4 pa_oe");
    bus_wr(2'd1, 8'h3C);
    bus_wr(2'd2, 8'h5A);
    chk(pb_out, 8'h3C, "R4 pb_out");
    chk(pc_out, 8'h5A, "R4 pc_out");
    chk(pc_oe, 8'hFF, "R4 pc_oe");
    bus_rd(2'd0, 8'hA5, "R4 pa read");
    bus_rd(2'd1, 8'h3C, "R2 pb read");
    bus_rd(2'd2, 8'h5A, "R2 pc read");

    // R6 bit set/reset
    bus_wr(2'd3, 8'h0F);
    chk(pc_out, 8'hDA, "R6 set bit7");
    bus_wr(2'd3, 8'h08);
    chk(pc_out, 8'hCA, "R6 clear bit4");

    // R3 R5 R7 mixed basic mode
    bus_wr(2'd3, 8'h8A);
    chk(pa_out, 8'h00, "R7 pa latch cleared");
    chk(pc_out, 8'h00, "R7 pc latch cleared");
    chk(pa_oe, 8'hFF, "R3 pa_oe out");
    chk(pb_oe, 8'h00, "R3 pb_oe in");
    chk(pc_oe, 8'h0F, "R3 pc_oe split");
    pb_in = 8'h77;
    bus_rd(2'd1, 8'h77, "R5 pb live 1");
    pb_in = 8'h11;
    bus_rd(2'd1, 8'h11, "R5 pb live 2");
    pc_in = 8'hB0;
    bus_rd(2'd2, 8'hB0, "R5 pc upper pins lower latch");
    pc_in = 8'hFF;
    settle();

    // R8 strobed input on port A, interrupt enabled
    bus_wr(2'd3, 8'hB0);
    chk(pc_oe, 8'hEF, "R12 pc_oe strobed in");
    chk(pc_out & pc_oe, 8'h00, "R8 idle flags");
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h3E;
    pc_in[4] = 1'b0;
    settle();
    chk(pc_out & pc_oe, 8'h20, "R8 ibf set");
    pa_in = 8'h99;
    pc_in[4] = 1'b1;
    settle();
    chk(pc_out & pc_oe, 8'h28, "R8 intr on strobe end");
    bus_rd(2'd2, 8'h38, "R12 status read");
    bus_rd(2'd0, 8'h3E, "R8 captured data");
    chk(pc_out & pc_oe, 8'h00, "R8 read clears");

    // R8 interrupt disabled
    bus_wr(2'd3, 8'h08);
    pc_in[4] = 1'b0;
    settle();
    pc_in[4] = 1'b1;
    settle();
    chk(pc_out & pc_oe, 8'h20, "R8 no intr when disabled");
    bus_rd(2'd0, 8'h99, "R8 second capture");

    // R9 R10 group B strobed output
    bus_wr(2'd3, 8'h9C);
    chk(pc_oe, 8'h0B, "R10 pc_oe group B out");
    chk(pc_out & pc_oe, 8'h02, "R10 obf idle high");
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'hC3);
    chk(pb_out, 8'hC3, "R9 pb_out");
    chk(pb_oe, 8'hFF, "R9 pb_oe");
    chk(pc_out & pc_oe, 8'h00, "R9 obf low after write");
    pc_in[2] = 1'b0;
    settle();
    chk(pc_out & pc_oe, 8'h02, "R9 ack clears obf");
    pc_in[2] = 1'b1;
    settle();
    chk(pc_out & pc_oe, 8'h03, "R10 intr on ack end");
    bus_wr(2'd1, 8'h44);
    chk(pc_out & pc_oe, 8'h00, "R9 write clears intr");

    // R11 bidirectional port A
    bus_wr(2'd3, 8'hC3);
    chk(pc_oe, 8'hA8, "R11 pc_oe bidir");
    chk(pc_out & pc_oe, 8'h80, "R11 idle");
    chk(pa_oe, 8'h00, "R11 pa hiz idle");
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'h6D);
    chk(pc_out & pc_oe, 8'h00, "R11 obf low");
    chk(pa_oe, 8'h00, "R11 pa hiz before ack");
    pc_in[6] = 1'b0;
    settle();
    chk(pa_oe, 8'hFF, "R11 pa driven on ack");
    chk(pa_out, 8'h6D, "R11 pa data");
    chk(pc_out & pc_oe, 8'h80, "R11 obf cleared");
    pc_in[6] = 1'b1;
    settle();
    chk(pa_oe, 8'h00, "R11 pa released");
    chk(pc_out & pc_oe, 8'h88, "R11 out intr");
    pa_in = 8'h42;
    pc_in[4] = 1'b0;
    settle();
    chk(pc_out & pc_oe, 8'hA8, "R11 ibf set");
    bus_rd(2'd0, 8'h42, "R11 input data");
    bus_rd(2'd2, 8'hCF, "R12 bidir status");
    pb_in = 8'h5A;
    bus_rd(2'd1, 8'h5A, "R11 port B independent");
    pc_in[4] = 1'b1;
    settle();

    if (sb_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R2: actual %0d pending reads expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule